// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block sits beside an SDRAM controller and watches the command pins it drives toward a four-bank memory. On every rising clock edge it decodes chip select, row strobe, column strobe, write enable, the bank address and address bit 10. It follows each bank between the idle and open states. It also times the intervals that govern legal command spacing: activate to column access, activate to activate across banks, the shortest and longest open time of a row, and the recovery after a precharge.

Every interval arrives as a cycle count on an input port. Software derives each count by dividing the nanosecond figure by the clock period and rounding up. The tracker reports two masks. One shows which banks may take a column command now. The other shows which banks may take an activate now. A sticky violation flag records the first illegal command or timing overrun seen after reset, together with a three-bit code for it.

Top module: `sdram_bank_guard`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), every bank is idle, every timer reads as expired, act_ready is all ones, col_ready is all zeros, violation is 0 and viol_code is 0.
- R2: Activate is cs_n=0, ras_n=0, cas_n=1, we_n=1. Read is cs_n=0, ras_n=1, cas_n=0, we_n=1. Write is cs_n=0, ras_n=1, cas_n=0, we_n=0. An activate at edge k opens an idle bank. A read or write to that bank at edge k+n is legal when n >= t_rcd and raises code 4 when n < t_rcd. col_ready for the bank is high in the cycle before every edge at which a column command would be legal.
- R3: A read or write to an idle bank raises code 3.
- R4: An activate to a bank that is already open raises code 1 and leaves that bank's timers untouched.
- R5: An activate at edge m raises code 2 in either of two cases. The first is m minus the last accepted activate edge (any bank) is below t_rrd. The second is m minus the last precharge edge of the target bank is below t_rp. act_ready shows per bank whether an activate would pass both tests.
- R6: Precharge is cs_n=0, ras_n=0, cas_n=1, we_n=0. With a10=0 it acts on the bank named by ba only. If that bank opened at edge k and the precharge is at edge k+n with n < t_ras_min, code 5 is raised. In every case an open target bank becomes idle. A precharge to an idle bank is legal and has no effect.
- R7: The precharge pattern with a10=1 closes every open bank. It raises code 5 if any open bank has been open for fewer than t_ras_min edges.
- R8: A bank opened at edge k and still open at edge k+t_ras_max+1 raises code 6. A precharge at edge k+t_ras_max is legal.
- R9: The violation flag and code are set at the edge after the offending edge and hold until reset. Later violations do not change them. When several violations occur at one edge, the lowest code is recorded. The codes are 1 activate to open bank, 2 activate too early, 3 column to idle bank, 4 column too early, 5 precharge too early, 6 open too long.
- R10: Cycles with cs_n=1 (whatever the other pins), the no-operation pattern (ras_n, cas_n, we_n = 1,1,1) and the other patterns (0,0,1 / 0,0,0 / 1,1,0) change no bank state and raise no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BAW (2) | Bank address |
| a10 | input | 1 | Address bit 10; selects all banks on precharge |
| t_rcd | input | TW (8) | Activate to column delay, cycles |
| t_rrd | input | TW (8) | Activate to activate spacing across banks, cycles |
| t_ras_min | input | TW (8) | Minimum open time, cycles |
| t_ras_max | input | TW (8) | Maximum open time, cycles |
| t_rp | input | TW (8) | Precharge recovery, cycles |
| col_ready | output | NB (4) | Per bank: a column command now would be legal |
| act_ready | output | NB (4) | Per bank: an activate now would be legal |
| violation | output | 1 | Sticky violation flag |
| viol_code | output | 3 | Code of the first violation |

## Verification
The hardest situation to reach is an open-time overrun. A bank has to stay open for more than t_ras_max edges while nothing else trips the sticky flag first. The bench therefore opens a single bank and holds the bus at no-operation for exactly t_ras_max and t_ras_max+1 edges, in two separate runs, to land on both sides of the limit. Same-edge collisions, such as reopening a bank one edge after opening it, check that the lowest code wins. Every cycle is also compared against a cycle-counting reference model held in the bench.

// File: rtl/sdram_guard_pkg.sv
`timescale 1ns/1ps
package sdram_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ACT   = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_PRE   = 3'd4,
        OP_OTHER = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        VC_NONE      = 3'd0,
        VC_ACT_OPEN  = 3'd1,
        VC_ACT_EARLY = 3'd2,
        VC_COL_IDLE  = 3'd3,
        VC_COL_EARLY = 3'd4,
        VC_PRE_EARLY = 3'd5,
        VC_OVERRUN   = 3'd6
    } vcode_e;

    localparam int NUM_VC = 6;

    typedef struct packed {
        op_e  op;
        logic all_banks;
    } cmd_t;

    function automatic cmd_t decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n,
                                         input logic a10);
        cmd_t c;
        c.op        = OP_NOP;
        c.all_banks = 1'b0;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c.op = OP_ACT;
                3'b101:  c.op = OP_READ;
                3'b100:  c.op = OP_WRITE;
                3'b010: begin
                    c.op        = OP_PRE;
                    c.all_banks = a10;
                end
                3'b111:  c.op = OP_NOP;
                default: c.op = OP_OTHER;
            endcase
        end
        return c;
    endfunction

    // Lowest-numbered hit wins; bit i of hits stands for code i+1.
    function automatic vcode_e pick_code(input logic [NUM_VC-1:0] hits);
        vcode_e r;
        r = VC_NONE;
        for (int i = NUM_VC - 1; i >= 0; i--) begin
            if (hits[i]) r = vcode_e'(3'(i + 1));
        end
        return r;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
    import sdram_guard_pkg::*;
#(
    parameter  int NB  = 4,
    localparam int BAW = $clog2(NB)
) (
    input  logic           cs_n,
    input  logic           ras_n,
    input  logic           cas_n,
    input  logic           we_n,
    input  logic           a10,
    input  logic [BAW-1:0] ba,
    output cmd_t           cmd_o,
    output logic [NB-1:0]  act_sel_o,
    output logic [NB-1:0]  pre_sel_o,
    output logic [NB-1:0]  col_sel_o
);
    logic [NB-1:0] bank_oh;

    always_comb begin
        cmd_o       = decode_pins(cs_n, ras_n, cas_n, we_n, a10);
        bank_oh     = '0;
        bank_oh[ba] = 1'b1;
        act_sel_o   = (cmd_o.op == OP_ACT) ? bank_oh : '0;
        col_sel_o   = (cmd_o.op == OP_READ || cmd_o.op == OP_WRITE) ? bank_oh : '0;
        if (cmd_o.op == OP_PRE)
            pre_sel_o = cmd_o.all_banks ? '1 : bank_oh;
        else
            pre_sel_o = '0;
    end
endmodule

// File: rtl/sdram_bank_timer.sv
`timescale 1ns/1ps
module sdram_bank_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act_i,
    input  logic          pre_i,
    input  logic [TW-1:0] t_rcd,
    input  logic [TW-1:0] t_ras_min,
    input  logic [TW-1:0] t_ras_max,
    input  logic [TW-1:0] t_rp,
    output logic          open_o,
    output logic          col_ok_o,
    output logic          pre_ok_o,
    output logic          rp_ok_o,
    output logic          overrun_o
);
    localparam logic [TW-1:0] SAT = '1;
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] act_age;
    logic [TW-1:0] rp_age;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o  <= 1'b0;
            act_age <= SAT;
            rp_age  <= SAT;
        end else begin
            if (act_i) begin
                open_o  <= 1'b1;
                act_age <= ONE;
            end else begin
                if (pre_i) open_o <= 1'b0;
                if (act_age != SAT) act_age <= act_age + ONE;
            end
            if (pre_i)              rp_age <= ONE;
            else if (rp_age != SAT) rp_age <= rp_age + ONE;
        end
    end

    always_comb begin
        col_ok_o  = open_o && (act_age >= t_rcd);
        pre_ok_o  = act_age >= t_ras_min;
        rp_ok_o   = rp_age >= t_rp;
        overrun_o = open_o && (act_age > t_ras_max);
    end

    AST_OPEN_AFTER_ACT: assert property (@(posedge clk) disable iff (rst)
        act_i |=> open_o) else $error("open after activate");   // R2
    AST_COL_WAITS: assert property (@(posedge clk) disable iff (rst)
        act_i && (t_rcd > ONE) |=> !col_ok_o) else $error("column too soon"); // R2
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        pre_i |=> !open_o) else $error("precharge did not close"); // R6
    AST_RECOVERY_WAIT: assert property (@(posedge clk) disable iff (rst)
        pre_i && (t_rp > ONE) |=> !rp_ok_o) else $error("recovery skipped"); // R5
endmodule

// File: rtl/sdram_rrd_timer.sv
`timescale 1ns/1ps
module sdram_rrd_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act_any_i,
    input  logic [TW-1:0] t_rrd,
    output logic          ok_o
);
    localparam logic [TW-1:0] SAT = '1;
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= SAT;
        else if (act_any_i)   age <= ONE;
        else if (age != SAT)  age <= age + ONE;
    end

    assign ok_o = age >= t_rrd;

    AST_RRD_SPACING: assert property (@(posedge clk) disable iff (rst)
        act_any_i && (t_rrd > ONE) |=> !ok_o) else $error("bank spacing skipped"); // R5
endmodule

// File: rtl/sdram_viol_latch.sv
`timescale 1ns/1ps
module sdram_viol_latch
    import sdram_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_VC-1:0] hits_i,
    output logic              violation_o,
    output vcode_e            code_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            violation_o <= 1'b0;
            code_o      <= VC_NONE;
        end else if (!violation_o && (|hits_i)) begin
            violation_o <= 1'b1;
            code_o      <= pick_code(hits_i);
        end
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        violation_o |=> violation_o && $stable(code_o)) else $error("flag not sticky"); // R9
    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (|hits_i) |=> violation_o) else $error("hit not latched"); // R9
    AST_CODE_SET: assert property (@(posedge clk) disable iff (rst)
        violation_o |-> code_o != VC_NONE) else $error("empty code"); // R9
endmodule

// File: rtl/sdram_bank_guard.sv
`timescale 1ns/1ps
module sdram_bank_guard
    import sdram_guard_pkg::*;
#(
    parameter  int NB  = 4,
    parameter  int TW  = 8,
    localparam int BAW = $clog2(NB)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           ras_n,
    input  logic           cas_n,
    input  logic           we_n,
    input  logic [BAW-1:0] ba,
    input  logic           a10,
    input  logic [TW-1:0]  t_rcd,
    input  logic [TW-1:0]  t_rrd,
    input  logic [TW-1:0]  t_ras_min,
    input  logic [TW-1:0]  t_ras_max,
    input  logic [TW-1:0]  t_rp,
    output logic [NB-1:0]  col_ready,
    output logic [NB-1:0]  act_ready,
    output logic           violation,
    output logic [2:0]     viol_code
);
    cmd_t              cmd;
    logic [NB-1:0]     act_sel, pre_sel, col_sel;
    logic [NB-1:0]     act_hit, pre_hit;
    logic [NB-1:0]     open_v, col_ok_v, pre_ok_v, rp_ok_v, over_v;
    logic              rrd_ok;
    logic              is_act, is_col, is_pre;
    logic [NUM_VC-1:0] hits;
    vcode_e            code;

    sdram_cmd_decode #(.NB(NB)) u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
        .ba(ba), .cmd_o(cmd), .act_sel_o(act_sel), .pre_sel_o(pre_sel),
        .col_sel_o(col_sel)
    );

    assign act_hit = act_sel & ~open_v;
    assign pre_hit = pre_sel & open_v;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdram_bank_timer #(.TW(TW)) u_bank (
            .clk(clk), .rst(rst), .act_i(act_hit[b]), .pre_i(pre_hit[b]),
            .t_rcd(t_rcd), .t_ras_min(t_ras_min), .t_ras_max(t_ras_max),
            .t_rp(t_rp), .open_o(open_v[b]), .col_ok_o(col_ok_v[b]),
            .pre_ok_o(pre_ok_v[b]), .rp_ok_o(rp_ok_v[b]), .overrun_o(over_v[b])
        );
    end

    sdram_rrd_timer #(.TW(TW)) u_rrd (
        .clk(clk), .rst(rst), .act_any_i(|act_hit), .t_rrd(t_rrd), .ok_o(rrd_ok)
    );

    always_comb begin
        is_act  = cmd.op == OP_ACT;
        is_col  = |col_sel;
        is_pre  = cmd.op == OP_PRE;
        hits[0] = is_act && open_v[ba];                                  // code 1
        hits[1] = is_act && (!rrd_ok || !rp_ok_v[ba]);                   // code 2
        hits[2] = is_col && !open_v[ba];                                 // code 3
        hits[3] = is_col && open_v[ba] && !col_ok_v[ba];                 // code 4
        hits[4] = is_pre && (|(pre_sel & open_v & ~pre_ok_v));           // code 5
        hits[5] = |over_v;                                               // code 6
    end

    sdram_viol_latch u_latch (
        .clk(clk), .rst(rst), .hits_i(hits), .violation_o(violation), .code_o(code)
    );

    assign viol_code = code;
    assign col_ready = col_ok_v;
    assign act_ready = ~open_v & rp_ok_v & {NB{rrd_ok}};

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (open_v == '0) && !violation && (viol_code == 3'd0)) else $error("reset state"); // R1
    AST_IDLE_COLUMN: assert property (@(posedge clk) disable iff (rst)
        is_col && !open_v[ba] |=> violation) else $error("idle column missed"); // R3
    AST_REOPEN: assert property (@(posedge clk) disable iff (rst)
        is_act && open_v[ba] |=> violation && $stable(open_v)) else $error("reopen missed"); // R4
    AST_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (|over_v) |=> violation) else $error("overrun missed"); // R8
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_NOP || cmd.op == OP_OTHER) |=> $stable(open_v)) else $error("state moved"); // R10
endmodule

// File: tb/sim_sdram_bank_guard.sv
`timescale 1ns/1ps
module sim_sdram_bank_guard;
    localparam int TRCD = 3, TRRD = 2, TRMIN = 5, TRMAX = 20, TRP = 3;
    localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4,
                   K_PALL = 5, K_DSEL = 6, K_REF = 7, K_BST = 8;

    logic clk = 0, rst = 1;
    logic cs_n = 0, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
    logic [1:0] ba = 0;
    logic [3:0] col_ready, act_ready;
    logic violation;
    logic [2:0] viol_code;

    sdram_bank_guard u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .t_rcd(8'(TRCD)), .t_rrd(8'(TRRD)),
        .t_ras_min(8'(TRMIN)), .t_ras_max(8'(TRMAX)), .t_rp(8'(TRP)),
        .col_ready(col_ready), .act_ready(act_ready), .violation(violation),
        .viol_code(viol_code)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct {
        int at; int code; logic [3:0] col; logic [3:0] act; bit full; string tag;
    } exp_t;
    exp_t q[$];

    // reference model
    int m_open[4], m_age[4], m_rp[4];
    int m_rrd, m_code;

    function automatic int sat(int v);
        return (v >= 255) ? 255 : v + 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0; m_age[i] = 255; m_rp[i] = 255;
        end
        m_rrd = 255; m_code = 0;
    endtask

    task automatic model_eval(int k, int b);
        bit h[7];
        bit isact, iscol, ispre;
        isact = (k == K_ACT);
        iscol = (k == K_RD) || (k == K_WR);
        ispre = (k == K_PRE) || (k == K_PALL);
        for (int i = 0; i < 7; i++) h[i] = 0;
        h[1] = isact && m_open[b] != 0;
        h[2] = isact && (m_rrd < TRRD || m_rp[b] < TRP);
        h[3] = iscol && m_open[b] == 0;
        h[4] = iscol && m_open[b] != 0 && m_age[b] < TRCD;
        for (int i = 0; i < 4; i++) begin
            if (ispre && (k == K_PALL || i == b) && m_open[i] != 0 && m_age[i] < TRMIN) h[5] = 1;
            if (m_open[i] != 0 && m_age[i] > TRMAX) h[6] = 1;
        end
        if (m_code == 0)
            for (int c = 6; c >= 1; c--) if (h[c]) m_code = c;
        for (int i = 0; i < 4; i++) begin
            m_age[i] = sat(m_age[i]); m_rp[i] = sat(m_rp[i]);
        end
        m_rrd = sat(m_rrd);
        if (isact && m_open[b] == 0) begin
            m_open[b] = 1; m_age[b] = 1; m_rrd = 1;
        end
        if (ispre)
            for (int i = 0; i < 4; i++)
                if ((k == K_PALL || i == b) && m_open[i] != 0) begin
                    m_open[i] = 0; m_rp[i] = 1;
                end
    endtask

    task automatic set_pins(int k, int b);
        ba = 2'(b); a10 = 0; cs_n = 0;
        case (k)
            K_ACT:  {ras_n, cas_n, we_n} = 3'b011;
            K_RD:   {ras_n, cas_n, we_n} = 3'b101;
            K_WR:   {ras_n, cas_n, we_n} = 3'b100;
            K_PRE:  {ras_n, cas_n, we_n} = 3'b010;
            K_PALL: begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1; end
            K_DSEL: begin cs_n = 1; {ras_n, cas_n, we_n} = 3'b011; end
            K_REF:  {ras_n, cas_n, we_n} = 3'b001;
            K_BST:  {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
    endtask

    // driver: one command per edge, expected outputs pushed to the scoreboard
    task automatic step(int k, int b, string tag);
        exp_t e;
        logic [3:0] col, act;
        @(negedge clk);
        set_pins(k, b);
        model_eval(k, b);
        for (int i = 0; i < 4; i++) begin
            col[i] = (m_open[i] != 0) && (m_age[i] >= TRCD);
            act[i] = (m_open[i] == 0) && (m_rp[i] >= TRP) && (m_rrd >= TRRD);
        end
        @(posedge clk); #1;
        set_pins(K_NOP, 0);
        e.at = cyc; e.code = m_code; e.col = col; e.act = act; e.full = 1; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(K_NOP, 0, tag);
    endtask

    // direct expectation on the code, written from the requirement
    task automatic expect_code(int code, string tag);
        exp_t e;
        e.at = cyc; e.code = code; e.col = 0; e.act = 0; e.full = 0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; set_pins(K_NOP, 0);
        @(posedge clk); #1;
        rst = 0;
        model_reset();
    endtask

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (violation !== (e.code != 0) || viol_code !== 3'(e.code)) begin
                failures++;
                $display("FAIL %s: violation=%0b code=%0d expected violation=%0b code=%0d",
                         e.tag, violation, viol_code, e.code != 0, e.code);
            end else if (e.full && (col_ready !== e.col || act_ready !== e.act)) begin
                failures++;
                $display("FAIL %s: col_ready=%b act_ready=%b expected col_ready=%b act_ready=%b",
                         e.tag, col_ready, act_ready, e.col, e.act);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        do_reset();
        step(K_NOP, 0, "R1 reset state"); expect_code(0, "R1 clean after reset");

        // R2 column too early, then on time
        do_reset();
        step(K_ACT, 0, "R2 act"); step(K_NOP, 0, "R2 wait"); step(K_RD, 0, "R2 early read");
        step(K_NOP, 0, "R2 after"); expect_code(4, "R2 early column code");
        do_reset();
        step(K_ACT, 1, "R2 act"); idle(2, "R2 wait"); step(K_WR, 1, "R2 timely write");
        step(K_RD, 1, "R2 read"); expect_code(0, "R2 legal column");

        // R3 column to idle bank
        do_reset();
        step(K_RD, 2, "R3 idle read"); step(K_NOP, 0, "R3 after"); expect_code(3, "R3 idle column code");

        // R4 activate to open bank
        do_reset();
        step(K_ACT, 0, "R4 act"); idle(5, "R4 wait"); step(K_ACT, 0, "R4 reopen");
        step(K_NOP, 0, "R4 after"); expect_code(1, "R4 reopen code");

        // R5 bank spacing and recovery
        do_reset();
        step(K_ACT, 0, "R5 act"); step(K_ACT, 1, "R5 close act"); expect_code(2, "R5 spacing code");
        do_reset();
        step(K_ACT, 0, "R5 act"); step(K_NOP, 0, "R5 gap"); step(K_ACT, 1, "R5 spaced act");
        expect_code(0, "R5 spaced legal");
        do_reset();
        step(K_ACT, 2, "R5 act"); idle(4, "R5 wait"); step(K_PRE, 2, "R5 pre");
        step(K_NOP, 0, "R5 recover"); step(K_ACT, 2, "R5 early reopen");
        expect_code(2, "R5 recovery code");

        // R6 single precharge
        do_reset();
        step(K_ACT, 3, "R6 act"); idle(3, "R6 wait"); step(K_PRE, 3, "R6 early pre");
        expect_code(5, "R6 early precharge code");
        do_reset();
        step(K_ACT, 3, "R6 act"); step(K_NOP, 0, "R6 gap"); step(K_ACT, 0, "R6 act other");
        idle(3, "R6 wait"); step(K_PRE, 3, "R6 timely pre"); step(K_PRE, 1, "R6 idle pre");
        idle(3, "R6 recover"); expect_code(0, "R6 legal precharge");

        // R7 precharge all
        do_reset();
        step(K_ACT, 0, "R7 act"); step(K_NOP, 0, "R7 gap"); step(K_ACT, 1, "R7 act");
        idle(3, "R7 wait"); step(K_PALL, 0, "R7 early all"); expect_code(5, "R7 early all code");
        do_reset();
        step(K_ACT, 0, "R7 act"); step(K_NOP, 0, "R7 gap"); step(K_ACT, 1, "R7 act");
        idle(4, "R7 wait"); step(K_PALL, 2, "R7 timely all"); idle(3, "R7 recover");
        step(K_ACT, 0, "R7 reopen"); expect_code(0, "R7 legal all");

        // R8 maximum open time
        do_reset();
        step(K_ACT, 0, "R8 act"); idle(TRMAX - 1, "R8 hold"); step(K_PRE, 0, "R8 last pre");
        expect_code(0, "R8 precharge at limit");
        do_reset();
        step(K_ACT, 0, "R8 act"); idle(TRMAX + 1, "R8 hold"); expect_code(6, "R8 overrun code");

        // R9 sticky and priority
        do_reset();
        step(K_RD, 0, "R9 first"); step(K_ACT, 0, "R9 act"); step(K_ACT, 0, "R9 second");
        expect_code(3, "R9 first code held");
        do_reset();
        step(K_ACT, 0, "R9 act"); step(K_ACT, 0, "R9 collide"); expect_code(1, "R9 lowest code");

        // R10 quiet patterns
        do_reset();
        step(K_ACT, 0, "R10 act"); step(K_DSEL, 1, "R10 deselect"); step(K_REF, 1, "R10 refresh pattern");
        step(K_BST, 2, "R10 stop pattern"); idle(3, "R10 wait");
        step(K_ACT, 1, "R10 bank still idle"); expect_code(0, "R10 no effect");

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule